// File: doc/BRIEF.md
# Bypassing Processor Write Buffer With Hazard Stall

This block sits between one processor port and a slow memory. Processor writes are placed in a small in-order queue in a single cycle, so the processor can move on at once. A controller drains the queue to memory one write at a time. Each queued entry stays in the queue until memory acknowledges that write.

Processor reads may overtake writes that are still queued. Before a read goes to memory, its address is compared with every valid queue entry, including the entry currently in flight. If any entry matches, the read waits until the matching writes have completed in memory. Queued data is never forwarded to a read.

The controller is a three-state machine:
- `ST_IDLE`: no memory request is active.
- `ST_WRITE`: the head entry is being written to memory.
- `ST_READ`: a processor read is being performed in memory.

Transitions:
- IDLE to READ: a read is requested and its address matches no queue entry.
- IDLE to WRITE: no read can go ahead and the queue is not empty.
- WRITE to IDLE: on the memory acknowledge, which also frees the head entry.
- READ to IDLE: on the memory acknowledge, which also completes the read to the processor.

Top module: `wrbuf_top`

## Requirements
- R1: A processor write (`cpu_req`=1, `cpu_we`=1) offered while the queue holds fewer than DEPTH entries is accepted in that cycle: `cpu_ready` is high.
- R2: While the queue holds DEPTH entries, `cpu_ready` stays low for writes until an entry is freed.
- R3: Queued writes reach memory in acceptance order, one at a time, with the same address and data. `mem_req`, `mem_we` and `mem_addr` are held until `mem_ack`, and an entry is freed only at its acknowledge.
- R4: A read whose address matches no queue entry is sent to memory ahead of the queued writes. When the port is free and such a read waits, the read is issued in the next cycle, before any further write.
- R5: A read whose address matches any valid queue entry, including the one in flight, is not sent to memory until every matching write has been acknowledged.
- R6: A write to an address that is already queued is accepted without stalling and is appended behind the earlier write.
- R7: A read completes in the cycle of its memory acknowledge. In that cycle `cpu_ready` is high and `cpu_rdata` carries `mem_rdata`.
- R8: After reset no memory request is active, the queue is empty, and a write would be accepted.
- R9: Every read returns the value of the latest earlier write to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_ready | output | 1 | Write accepted, or read complete |
| cpu_rdata | output | DW | Read data, valid when a read completes |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | One-cycle completion pulse from memory |
| mem_rdata | input | DW | Memory read data, valid with `mem_ack` |

## Verification
The bench reads an address whose write is already in flight. A design that excludes the in-flight entry from the address compare would return the old memory value.

It queues four writes and then reads an unrelated address. The read must finish after exactly one write has been acknowledged. A design that did not let reads overtake writes would finish it only after all four.

It reads the third queued address. The read must finish after exactly three write acknowledges. A design that gave the next write priority over the waiting read would show four. A design that ignored the hazard would return stale data.

It also fills the queue to check back-pressure, and it writes one address twice in a row. The second write must not stall, and a later read must return the newer value.

// File: rtl/wrbuf_pkg.sv
package wrbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } wb_state_e;
endpackage

// File: rtl/wrbuf_fifo.sv
module wrbuf_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic [AW-1:0] look_addr,
    output logic          full,
    output logic          empty,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          hit,
    output logic [CW-1:0] fill
);
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] hit_vec;
    logic [PW-1:0]    wr_p, rd_p;
    logic [CW-1:0]    cnt_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            wr_p  <= '0;
            rd_p  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                vld_q[wr_p] <= 1'b1;
                wr_p        <= step(wr_p);
            end
            if (pop) begin
                vld_q[rd_p] <= 1'b0;
                rd_p        <= step(rd_p);
            end
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_p] <= push_addr;
            data_q[wr_p] <= push_data;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = vld_q[i] && (addr_q[i] == look_addr);
    end

    assign hit       = |hit_vec;
    assign fill      = cnt_q;
    assign full      = (cnt_q == CW'(DEPTH));
    assign empty     = (cnt_q == '0);
    assign head_addr = addr_q[rd_p];
    assign head_data = data_q[rd_p];
endmodule

// File: rtl/wrbuf_ctrl.sv
module wrbuf_ctrl
    import wrbuf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_req,
    input  logic          rd_hit,
    input  logic          wr_pend,
    input  logic [AW-1:0] rd_addr,
    input  logic [AW-1:0] head_addr,
    input  logic          mem_ack,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic          pop,
    output logic          rd_done
);
    wb_state_e     state_q, state_d;
    logic [AW-1:0] rd_addr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_req && !rd_hit) state_d = ST_READ;
                else if (wr_pend)      state_d = ST_WRITE;
            end
            ST_WRITE: if (mem_ack) state_d = ST_IDLE;
            ST_READ:  if (mem_ack) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rd_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_READ) rd_addr_q <= rd_addr;
        end
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = head_addr;
        pop      = 1'b0;
        rd_done  = 1'b0;
        unique case (state_q)
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                pop     = mem_ack;
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = rd_addr_q;
                rd_done  = mem_ack;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/wrbuf_top.sv
module wrbuf_top #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_ready,
    output logic [DW-1:0] cpu_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    logic          full, empty, rd_hit, pop, rd_done, push;
    logic [AW-1:0] head_addr;
    logic [CW-1:0] fill;

    assign push = cpu_req && cpu_we && !full;

    wrbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_addr(cpu_addr), .push_data(cpu_wdata),
        .pop(pop), .look_addr(cpu_addr),
        .full(full), .empty(empty),
        .head_addr(head_addr), .head_data(mem_wdata),
        .hit(rd_hit), .fill(fill)
    );

    wrbuf_ctrl #(.AW(AW)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .rd_req(cpu_req && !cpu_we), .rd_hit(rd_hit), .wr_pend(!empty),
        .rd_addr(cpu_addr), .head_addr(head_addr), .mem_ack(mem_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .pop(pop), .rd_done(rd_done)
    );

    assign cpu_ready = cpu_we ? !full : rd_done;
    assign cpu_rdata = mem_rdata;
endmodule

// File: rtl/wrbuf_chk.sv
module wrbuf_chk #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic          cpu_ready,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [CW-1:0] fill,
    input logic          rd_hit
);
    p_wr_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && fill < CW'(DEPTH)) |-> cpu_ready);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == CW'(DEPTH)) |-> !(cpu_we && cpu_ready));

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

    p_drain_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (fill != '0));

    p_pop_at_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack && !(cpu_req && cpu_we && cpu_ready))
        |=> (fill == $past(fill) - 1'b1));

    p_read_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req && cpu_req && !cpu_we && !rd_hit) |=> (mem_req && !mem_we));

    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |-> !rd_hit);

    p_read_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_ready) |-> (mem_req && !mem_we && mem_ack));
endmodule

bind wrbuf_top wrbuf_chk #(.DEPTH(DEPTH), .AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_ack(mem_ack), .mem_addr(mem_addr), .fill(fill), .rd_hit(rd_hit)
);

// File: tb/test_wrbuf_top.sv
module test_wrbuf_top;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int WR_LAT = 100;
    localparam int RD_LAT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    int total = 0, bad = 0, wr_acks = 0, cycles = 0;
    logic [DW-1:0] mem_model [2**AW];
    logic [DW-1:0] shadow [2**AW];
    logic [AW-1:0] exp_wa [$];
    logic [DW-1:0] exp_wd [$];
    logic [DW-1:0] exp_rd [$];

    always #4 clk = ~clk;

    wrbuf_top #(.DEPTH(4), .AW(AW), .DW(DW)) i_wrbuf_top (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    // slow memory model
    int mcnt = 0;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            mem_ack <= 1'b0;
            mcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (mcnt == (mem_we ? WR_LAT : RD_LAT) - 1) begin
                mcnt    <= 0;
                mem_ack <= 1'b1;
                if (mem_we) mem_model[mem_addr] <= mem_wdata;
                else        mem_rdata <= mem_model[mem_addr];
            end else begin
                mcnt <= mcnt + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: compares memory writes and read results against the queues
    always @(negedge clk) begin
        #2;
        if (rst_n && mem_req && mem_we && mem_ack) begin
            wr_acks++;
            if (exp_wa.size() == 0) check(1'b0, "R3 unexpected write", int'(mem_addr), -1);
            else begin
                logic [AW-1:0] ea;
                logic [DW-1:0] ed;
                ea = exp_wa.pop_front();
                ed = exp_wd.pop_front();
                check(mem_addr == ea, "R3 write order addr", int'(mem_addr), int'(ea));
                check(mem_wdata == ed, "R3 write data", int'(mem_wdata), int'(ed));
            end
        end
        if (rst_n && cpu_req && !cpu_we && cpu_ready) begin
            if (exp_rd.size() == 0) check(1'b0, "R7 unexpected read", int'(cpu_rdata), -1);
            else begin
                logic [DW-1:0] er;
                er = exp_rd.pop_front();
                check(cpu_rdata == er, "R9 read value", int'(cpu_rdata), int'(er));
            end
        end
    end

    // drivers: called just after a falling edge; leave at a falling edge
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int waits);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        waits = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk); #1; waits++;
        end
        exp_wa.push_back(a);
        exp_wd.push_back(d);
        shadow[a] = d;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, output int acks_at_done);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        exp_rd.push_back(shadow[a]);
        #1;
        while (!cpu_ready) begin
            @(negedge clk); #1;
        end
        #2;
        acks_at_done = wr_acks;
        @(negedge clk);
    endtask

    task automatic go_idle(input int n);
        cpu_req = 1'b0; cpu_we = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 2**AW; i++) begin
            mem_model[i] = '0;
            shadow[i] = '0;
        end
    end

    // watchdog
    initial begin
        wait (cycles > 20000);
        check(1'b0, "watchdog", cycles, 20000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int w, base, acks;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(mem_req == 1'b0, "R8 no request after reset", int'(mem_req), 0);
        cpu_we = 1'b1; #1;
        check(cpu_ready == 1'b1, "R8 write ready after reset", int'(cpu_ready), 1);
        cpu_we = 1'b0;
        @(negedge clk);

        // R5: read of an address whose write is in flight
        do_write(8'd50, 16'h00A5, w);
        go_idle(3);
        base = wr_acks;
        do_read(8'd50, acks);
        check(acks - base == 1, "R5 read waits for in-flight write", acks - base, 1);
        go_idle(2);

        // R1: four back-to-back writes accepted in one cycle each
        for (int i = 0; i < 4; i++) begin
            do_write(AW'(10 + i), DW'(16'h0100 + i), w);
            check(w == 0, "R1 write accepted in one cycle", w, 0);
        end
        // R4: unrelated read overtakes queued writes
        base = wr_acks;
        do_read(8'd50, acks);
        check(acks - base == 1, "R4 read bypasses queued writes", acks - base, 1);
        // R5 + R4 priority: read of third queued address
        do_read(8'd12, acks);
        check(acks - base == 3, "R5 read stalls until matching write done", acks - base, 3);

        // R2: fill the queue, then the next write must be held off
        for (int i = 0; i < 3; i++) do_write(AW'(20 + i), DW'(16'h0200 + i), w);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'd23; #1;
        check(cpu_ready == 1'b0, "R2 full queue blocks write", int'(cpu_ready), 0);
        @(negedge clk);
        do_write(8'd23, 16'h0223, w);
        check(w > 10, "R2 write waited for a free entry", w, 11);
        go_idle(600);

        // R6: same-address writes do not stall; later read sees newest value
        do_write(8'd30, 16'h0001, w);
        check(w == 0, "R6 first write no stall", w, 0);
        do_write(8'd30, 16'h0002, w);
        check(w == 0, "R6 repeat address write no stall", w, 0);
        do_read(8'd30, acks);
        check(shadow[30] == 16'h0002, "R6 newest value expected", int'(shadow[30]), 2);
        do_read(8'd11, acks);  // R7 plain read of a drained address
        go_idle(300);

        check(exp_wa.size() == 0, "R3 all writes drained", exp_wa.size(), 0);
        check(exp_rd.size() == 0, "R7 all reads completed", exp_rd.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule